// File: doc/BRIEF.md
# Periodic Tick Down-Counter Timer

This block is a register-mapped interval timer. A 24-bit counter steps down by one on every count tick. When it is at zero, the next tick loads the value held in the reload register, so the period is the reload value plus one tick. Each step from one to zero sets a sticky status flag and can also raise a one-cycle interrupt request. The count tick comes from one of two sources, picked by a control bit: every core clock cycle, or a single-cycle reference strobe supplied from outside.

Software reaches the timer through a simple synchronous bus with four word slots. Slot 0 holds control and status, slot 1 holds the reload value and slot 2 holds the current count. Slot 3 is a placeholder that always reads zero. Reading the control slot clears the status flag. Any write to the count slot forces the counter to zero and also clears the flag, so the next tick starts a fresh period. Writing zero to the reload slot does not stop the counter at once: it runs down to zero, then stays there.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, reload and count slots all read zero, and the interrupt output is low.
- R2: While enabled, the count drops by exactly one on each count tick. While disabled, it holds its value whatever the tick inputs do.
- R3: With control bit 2 set, every core clock cycle is a count tick. With bit 2 clear, only cycles where the reference strobe is high are count ticks.
- R4: A count tick taken while the count is zero loads the reload value. This also covers the first tick after enabling with a zero count, and no flag or interrupt results.
- R5: When the count steps from 1 to 0, control bit 16 (the status flag) becomes 1. A read of slot 0 returns the flag and clears it.
- R6: If a read of slot 0 and a 1-to-0 step fall in the same cycle, the read returns bit 16 as 1 and the flag remains set afterwards.
- R7: A write of any data to slot 2 sets the count to zero and clears the status flag. The write takes priority over a tick in the same cycle.
- R8: With a reload value of zero, the counter comes to rest at zero after its current run. Later ticks neither change it nor set the flag again.
- R9: With control bit 1 set, the interrupt output is high for exactly one cycle, the cycle after the edge where the count steps from 1 to 0. With bit 1 clear, it stays low.
- R10: Read data appears the cycle after the read enable. In slot 0, only bits 0 (enable), 1, 2 and 16 can read nonzero, and writes to bit 16 are ignored. In slots 1 and 2, bits 31:24 read zero and ignore writes. Slot 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick_i | input | 1 | Reference count strobe, one cycle per tick |
| bus_addr_i | input | 2 | Word slot select |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | 32 | Write data |
| bus_re_i | input | 1 | Read enable |
| bus_rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The embedded assertions check the following on every cycle:
- the one-step decrement and the hold on idle cycles,
- the load from reload at zero,
- the clear on a count-slot write,
- the flag's set, clear and collision rules,
- the single-cycle interrupt, which occurs only with the count at zero.

The bench scenarios cover what needs software-visible sequences:
- the period seen through bus reads,
- the choice of tick source,
- the stop after a zero reload,
- the suppression of the interrupt when it is disabled,
- the masking of reserved bits and the empty slot.

// File: rtl/tick_pkg.sv
// Shared definitions for the tick timer: slot map and control bit positions.
// Assumes a word-indexed bus with four slots.
package tick_pkg;

    typedef enum logic [1:0] {
        SLOT_CTRL   = 2'd0,
        SLOT_RELOAD = 2'd1,
        SLOT_COUNT  = 2'd2,
        SLOT_SPARE  = 2'd3
    } slot_e;

    localparam int CB_RUN   = 0;
    localparam int CB_IRQEN = 1;
    localparam int CB_CORE  = 2;
    localparam int CB_FLAG  = 16;

    typedef struct packed {
        logic core_src;
        logic irq_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/tick_regfile.sv
// Register slots and bus read path of the tick timer.
// Holds the control bits and the reload value. Decodes writes to the count
// slot and reads of the control slot. Read data is registered and only
// updated on a read. Assumes ADDR_W >= 2; any set upper address bits
// select nothing.
module tick_regfile
    import tick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              flag_i,
    input  logic              flag_set_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              count_wr_o,
    output logic              ctrl_rd_o,
    output logic [DATA_W-1:0] rdata_o
);

    slot_e             slot;
    logic              mapped;
    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    assign slot = slot_e'(addr_i[1:0]);

    // Address range check; the variant depends on the address width.
    generate
        if (ADDR_W > 2) begin : g_wide
            assign mapped = (addr_i[ADDR_W-1:2] == '0);
        end else begin : g_narrow
            assign mapped = 1'b1;
        end
    endgenerate

    assign count_wr_o = we_i && mapped && (slot == SLOT_COUNT);
    assign ctrl_rd_o  = re_i && mapped && (slot == SLOT_CTRL);

    // Control and reload slot storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else if (we_i && mapped) begin
            if (slot == SLOT_CTRL) begin
                ctrl_q.run      <= wdata_i[CB_RUN];
                ctrl_q.irq_en   <= wdata_i[CB_IRQEN];
                ctrl_q.core_src <= wdata_i[CB_CORE];
            end
            if (slot == SLOT_RELOAD) begin
                reload_q <= wdata_i[CNT_W-1:0];
            end
        end
    end

    // Read multiplexer; a flag being set in this cycle is reported as set.
    always_comb begin
        rd_mux = '0;
        if (mapped) begin
            unique case (slot)
                SLOT_CTRL: begin
                    rd_mux[CB_RUN]   = ctrl_q.run;
                    rd_mux[CB_IRQEN] = ctrl_q.irq_en;
                    rd_mux[CB_CORE]  = ctrl_q.core_src;
                    rd_mux[CB_FLAG]  = flag_i | flag_set_i;
                end
                SLOT_RELOAD: rd_mux = DATA_W'(reload_q);
                SLOT_COUNT:  rd_mux = DATA_W'(count_i);
                SLOT_SPARE:  rd_mux = '0;
            endcase
        end
    end

    // Registered read data, updated only on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (re_i) rdata_q <= rd_mux;
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;
    assign rdata_o  = rdata_q;

    // R10
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re_i && slot == SLOT_SPARE) |=> rdata_o == '0);

    // R10
    reload_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re_i && mapped && slot == SLOT_RELOAD) |=> rdata_o[DATA_W-1:CNT_W] == '0);

endmodule

// File: rtl/tick_core.sv
// Down-counter of the tick timer.
// Picks the tick source and steps the count down on each tick. At zero, a
// tick loads the reload value instead. A count-slot write clears the count
// and wins over a tick in the same cycle. Flags the 1-to-0 step to the
// status logic. Assumes the reference strobe is synchronous to clk.
module tick_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             core_src_i,
    input  logic             ref_tick_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             to_zero_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             tick;
    logic [CNT_W-1:0] count_q;

    // Tick source select: every cycle, or only on the reference strobe.
    assign tick      = run_i && (core_src_i || ref_tick_i);
    assign to_zero_o = tick && !clr_i && (count_q == ONE);

    // Count register: clear, load on zero, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (tick) begin
            if (count_q == '0) count_q <= reload_i;
            else               count_q <= count_q - ONE;
        end
    end

    assign count_o = count_q;

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_i && count_q != '0) |=> count_q == $past(count_q) - ONE);

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr_i) |=> $stable(count_q));

    // R4
    wrap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_i && count_q == '0) |=> count_q == $past(reload_i));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> count_q == '0);

endmodule

// File: rtl/tick_status.sv
// Sticky status flag and interrupt pulse of the tick timer.
// A 1-to-0 step sets the flag. A control read or a count write clears it,
// but a set in the same cycle wins. The interrupt is a registered one-cycle
// pulse on each step, gated by the interrupt enable.
module tick_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);

    logic flag_q;
    logic irq_q;

    // Flag register: set has priority over the read and write clears.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_q <= 1'b0;
        else if (set_i)          flag_q <= 1'b1;
        else if (rd_i || clr_i)  flag_q <= 1'b0;
    end

    // Interrupt pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= set_i && irq_en_i;
    end

    assign flag_o = flag_q;
    assign irq_o  = irq_q;

    // R6
    collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && rd_i) |=> flag_o);

    // R5
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !set_i) |=> !flag_o);

    // R7
    write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

endmodule

// File: rtl/tick_timer.sv
// Top of the tick timer: ties together the register slots, the counter and
// the status logic. Assumes one synchronous clock domain and a
// synchronous active-low reset.
module tick_timer
    import tick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_re_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             count_wr;
    logic             ctrl_rd;
    logic             to_zero;
    logic             flag;

    tick_regfile #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr_i),
        .we_i       (bus_we_i),
        .wdata_i    (bus_wdata_i),
        .re_i       (bus_re_i),
        .count_i    (count),
        .flag_i     (flag),
        .flag_set_i (to_zero),
        .ctrl_o     (ctrl),
        .reload_o   (reload),
        .count_wr_o (count_wr),
        .ctrl_rd_o  (ctrl_rd),
        .rdata_o    (bus_rdata_o)
    );

    tick_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (ctrl.run),
        .core_src_i (ctrl.core_src),
        .ref_tick_i (ref_tick_i),
        .clr_i      (count_wr),
        .reload_i   (reload),
        .count_o    (count),
        .to_zero_o  (to_zero)
    );

    tick_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (to_zero),
        .rd_i     (ctrl_rd),
        .clr_i    (count_wr),
        .irq_en_i (ctrl.irq_en),
        .flag_o   (flag),
        .irq_o    (irq_o)
    );

    // R9
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> count == '0);

endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [1:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    int irq_seen = 0;
    logic pend = 1'b0;
    logic done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    tick_timer dut (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick),
        .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_re_i(re), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver tasks: each starts just after a negedge and ends just after the next.
    task automatic bus_read(input logic [1:0] a, input logic [31:0] exp, input string tag);
        addr = a; re = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic ticks(input int n);
        ref_tick = 1'b1;
        repeat (n) @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic read_on_tick(input logic [31:0] exp, input string tag);
        addr = 2'd0; re = 1'b1; ref_tick = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        re = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Monitor: note reads at the edge, compare returned data half a cycle later.
    always @(posedge clk) pend <= re;
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                check_eq("scoreboard underflow", 32'hDEAD, 32'h0);
            end else begin
                check_eq(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
        if (rst_n && irq) irq_seen++;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_eq("R1 irq after reset", {31'b0, irq}, 32'h0);
        bus_read(2'd0, 32'h0, "R1 ctrl reset");
        bus_read(2'd1, 32'h0, "R1 reload reset");
        bus_read(2'd2, 32'h0, "R1 count reset");

        // R10 layout and masking
        bus_write(2'd1, 32'hFF00_0005);
        bus_read(2'd1, 32'h0000_0005, "R10 reload upper bits");
        bus_write(2'd0, 32'hFFFF_FFF8);
        bus_read(2'd0, 32'h0, "R10 ctrl reserved and flag bits");
        bus_write(2'd2, 32'h00AB_CDEF);
        bus_read(2'd2, 32'h0, "R7 count write clears");
        bus_read(2'd3, 32'h0, "R10 spare slot");

        // R4, R5, R9 with reference strobe source
        bus_write(2'd0, 32'h3);
        bus_read(2'd0, 32'h3, "R10 ctrl readback");
        ticks(1);
        bus_read(2'd2, 32'd5, "R4 first tick loads reload");
        bus_read(2'd0, 32'h3, "R4 no flag on load");
        ticks(4);
        bus_read(2'd2, 32'd1, "R2 decrement per tick");
        check_eq("R9 no irq before zero", irq_seen, 0);
        ticks(1);
        bus_read(2'd0, 32'h0001_0003, "R5 flag on 1 to 0");
        bus_read(2'd0, 32'h3, "R5 read clears flag");
        check_eq("R9 one irq cycle", irq_seen, 1);
        ticks(1);
        bus_read(2'd2, 32'd5, "R4 reload after zero");

        // R6 read and set collide
        ticks(4);
        read_on_tick(32'h0001_0003, "R6 colliding read sees flag");
        bus_read(2'd0, 32'h0001_0003, "R6 flag kept");
        bus_read(2'd0, 32'h3, "R6 cleared by later read");
        check_eq("R9 second irq", irq_seen, 2);

        // R7 count write clears flag and count
        ticks(6);
        bus_write(2'd2, 32'h123);
        bus_read(2'd2, 32'h0, "R7 count cleared");
        bus_read(2'd0, 32'h3, "R7 flag cleared");
        ticks(2);
        bus_write(2'd2, 32'hFFFF_FFFF);
        bus_read(2'd2, 32'h0, "R7 mid-run clear");
        ticks(1);
        bus_read(2'd2, 32'd5, "R7 restart from reload");

        // R9 interrupt disabled
        bus_write(2'd0, 32'h1);
        ticks(5);
        bus_read(2'd0, 32'h0001_0001, "R9 flag without irq");
        check_eq("R9 irq suppressed", irq_seen, 3);

        // R8 zero reload stops at next wrap
        bus_write(2'd1, 32'd3);
        ticks(1);
        bus_write(2'd1, 32'd0);
        ticks(3);
        bus_read(2'd0, 32'h0001_0001, "R8 final run flags");
        ticks(4);
        bus_read(2'd2, 32'h0, "R8 rests at zero");
        bus_read(2'd0, 32'h1, "R8 no further flag");

        // R2 hold while disabled; R3 strobe source idle
        bus_write(2'd1, 32'd7);
        ticks(2);
        bus_write(2'd0, 32'h0);
        ticks(3);
        bus_read(2'd2, 32'd6, "R2 hold while disabled");
        bus_write(2'd0, 32'h1);
        repeat (20) @(negedge clk);
        bus_read(2'd2, 32'd6, "R3 no strobe no tick");

        // R3 core clock source: 11 ticks = load 100 then 10 steps
        bus_write(2'd0, 32'h0);
        bus_write(2'd2, 32'h0);
        bus_write(2'd1, 32'd100);
        bus_write(2'd0, 32'h5);
        repeat (10) @(negedge clk);
        bus_write(2'd0, 32'h0);
        bus_read(2'd2, 32'd90, "R3 core clock ticks");
        check_eq("R9 irq total", irq_seen, 3);

        @(negedge clk);
        check_eq("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        summary();
    end

endmodule